// File: doc/BRIEF.md
# Speculative Cache Line State Tracker

This block keeps the coherence state of every line of a small direct-indexed private first-level cache. That cache serves one core running thread-level speculation. Besides invalid, shared and modified, a line can be marked speculatively read (SpS) or speculatively written (SpE). Each line also records the 2-bit order ID of the speculative thread that last marked it. Thread IDs express logical program order, and a numerically smaller ID is logically earlier. Local loads and stores move lines between states. A store that gains ownership broadcasts an invalidation tagged with the local thread ID.

The block watches invalidations arriving from the bus. If one comes from a logically earlier thread and lands on a speculatively marked line, the speculation has read or written stale data. The block then pulses a squash request to the core and, on the same clock edge, drops every speculative mark so the thread can start again. Commit and squash commands from the core either keep or discard the speculative marks on all lines in a single cycle. Data storage, the bus protocol and re-execution belong to the surrounding system.

Top module: `spec_line_tracker`

## Requirements
- R1: After reset every line is invalid, and `resp_valid`, `squash_req` and `bc_valid` are low.
- R2: A request is accepted when it arrives in a cycle with no commit, no squash command and no ordering violation. On the following cycle `resp_valid` is high, and `resp_hit` is high when the line at index `req_addr[IDX_W-1:0]` held tag `req_addr[ADDR_W-1:IDX_W]` and was not invalid. `resp_state` gives the line's new state, coded as invalid=0, shared=1, modified=2, SpS=3, SpE=4.
- R3: A load that misses allocates the line as shared (non-speculative) or SpS (speculative). A speculative load that hits a shared or modified line moves it to SpS. A non-speculative load never changes a line it hits.
- R4: A speculative store leaves the line in SpE. A non-speculative store leaves it modified, or SpE if the line was speculatively marked. When the line was not already modified or SpE (a miss included), `bc_valid` rises one cycle later with `bc_addr` equal to the request address and `bc_tid` equal to `own_tid`.
- R5: An invalidation that matches a non-speculative line, or comes from a thread with an ID greater than or equal to the line's recorded ID, makes the line invalid and raises no squash.
- R6: An invalidation whose ID is lower than the recorded ID of a matching SpS or SpE line raises `squash_req` for exactly one cycle, in the next cycle. On the same edge that line becomes invalid, every other SpE line becomes invalid, and every other SpS line becomes shared.
- R7: A commit moves every SpS line to shared and every SpE line to modified in one cycle.
- R8: A squash command moves every SpE line to invalid and every SpS line to shared in one cycle. If commit and squash command are both high, the squash command wins.
- R9: After a squash request, invalidations still invalidate matching lines but raise no further squash until `restart` is pulsed.
- R10: An invalidation carrying `inv_tid` equal to `own_tid` is ignored.
- R11: A request arriving with a commit, a squash command or an ordering violation is dropped. It gives no response, no broadcast and no state change.
- R12: When an invalidation and a request address the same line in one cycle, the invalidation is applied first, and the request sees the invalidated line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_tid | input | TID_W | Order ID of the thread on the local core |
| req_valid | input | 1 | Local access request |
| req_write | input | 1 | Request is a store |
| req_spec | input | 1 | Request is speculative |
| req_addr | input | ADDR_W | Line address, tag above index |
| inv_valid | input | 1 | Incoming bus invalidation |
| inv_addr | input | ADDR_W | Line address of the invalidation |
| inv_tid | input | TID_W | Order ID of the invalidating thread |
| commit | input | 1 | Make all speculative marks permanent |
| squash_cmd | input | 1 | Discard all speculative marks |
| restart | input | 1 | Thread restarted; re-arms squash detection |
| resp_valid | output | 1 | Response to an accepted request |
| resp_hit | output | 1 | Request hit a valid line with matching tag |
| resp_state | output | 3 | Line state after the request |
| squash_req | output | 1 | One-cycle squash request to the core |
| bc_valid | output | 1 | Outgoing invalidation broadcast |
| bc_addr | output | ADDR_W | Broadcast line address |
| bc_tid | output | TID_W | Broadcast thread ID |

## Verification
The bench builds the block with IDX_W=3, TAG_W=6 and TID_W=2. That gives eight lines, so one run can hold a speculatively read line, a speculatively written line and plain lines side by side, and then show how commit, squash and violation treat each kind. The 6-bit tag allows two addresses on the same index, which exercises replacement and tag mismatch. With the full 2-bit ID and a local ID of 2, invalidations from an earlier thread, a later thread and the local thread can all be sent.

// File: rtl/spec_trk_pkg.sv
`timescale 1ns/1ps
package spec_trk_pkg;

  typedef enum logic [2:0] {
    LN_INV = 3'd0,
    LN_SHR = 3'd1,
    LN_MOD = 3'd2,
    LN_SPS = 3'd3,
    LN_SPE = 3'd4
  } ln_state_e;

  function automatic logic is_spec(ln_state_e s);
    return (s == LN_SPS) || (s == LN_SPE);
  endfunction

  // keep speculative work
  function automatic ln_state_e commit_map(ln_state_e s);
    case (s)
      LN_SPS:  return LN_SHR;
      LN_SPE:  return LN_MOD;
      default: return s;
    endcase
  endfunction

  // discard speculative work
  function automatic ln_state_e clear_map(ln_state_e s);
    case (s)
      LN_SPS:  return LN_SHR;
      LN_SPE:  return LN_INV;
      default: return s;
    endcase
  endfunction

endpackage

// File: rtl/spec_trk_order.sv
`timescale 1ns/1ps
module spec_trk_order #(
  parameter int TID_W = 2
) (
  input  logic [TID_W-1:0] a_tid,
  input  logic [TID_W-1:0] b_tid,
  output logic             a_older
);

  // smaller ID is logically earlier in program order
  assign a_older = (a_tid < b_tid);

endmodule

// File: rtl/spec_trk_line.sv
`timescale 1ns/1ps
module spec_trk_line
  import spec_trk_pkg::*;
#(
  parameter int TAG_W = 6,
  parameter int TID_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TID_W-1:0] own_tid,
  input  logic             inv_sel,
  input  logic [TAG_W-1:0] inv_tag,
  input  logic [TID_W-1:0] inv_tid,
  input  logic             req_sel,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             req_write,
  input  logic             req_spec,
  input  logic             do_commit,
  input  logic             do_clear,
  output logic             hit_now,
  output logic             viol,
  output logic             bc_need,
  output ln_state_e        nxt_state
);

  ln_state_e        state_q;
  ln_state_e        s_mid;
  ln_state_e        s_req;
  logic [TAG_W-1:0] tag_q;
  logic [TID_W-1:0] tid_q;
  logic             inv_hit;
  logic             inv_older;
  logic             active;

  spec_trk_order #(.TID_W(TID_W)) ord_i (
    .a_tid   (inv_tid),
    .b_tid   (tid_q),
    .a_older (inv_older)
  );

  always_comb begin
    inv_hit = inv_sel && (state_q != LN_INV) && (tag_q == inv_tag);
    viol    = inv_hit && is_spec(state_q) && inv_older;
    // the invalidation is applied before the request
    s_mid   = inv_hit ? LN_INV : state_q;
    hit_now = (s_mid != LN_INV) && (tag_q == req_tag);
    active  = req_sel && !do_commit && !do_clear;

    if (!hit_now) begin
      if (req_write) s_req = req_spec ? LN_SPE : LN_MOD;
      else           s_req = req_spec ? LN_SPS : LN_SHR;
    end else if (req_write) begin
      s_req = (req_spec || is_spec(s_mid)) ? LN_SPE : LN_MOD;
    end else if (req_spec) begin
      s_req = ((s_mid == LN_SHR) || (s_mid == LN_MOD)) ? LN_SPS : s_mid;
    end else begin
      s_req = s_mid;
    end

    bc_need = active && req_write &&
              (!hit_now || ((s_mid != LN_MOD) && (s_mid != LN_SPE)));

    if (do_clear)       nxt_state = clear_map(s_mid);
    else if (do_commit) nxt_state = commit_map(s_mid);
    else if (active)    nxt_state = s_req;
    else                nxt_state = s_mid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LN_INV;
      tag_q   <= '0;
      tid_q   <= '0;
    end else begin
      state_q <= nxt_state;
      if (active && !hit_now) tag_q <= req_tag;
      if (active && req_spec) tid_q <= own_tid;
    end
  end

endmodule

// File: rtl/spec_line_tracker.sv
`timescale 1ns/1ps
module spec_line_tracker
  import spec_trk_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 6,
  parameter int TID_W = 2,
  localparam int ADDR_W = IDX_W + TAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TID_W-1:0]  own_tid,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_spec,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  input  logic [TID_W-1:0]  inv_tid,
  input  logic              commit,
  input  logic              squash_cmd,
  input  logic              restart,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [2:0]        resp_state,
  output logic              squash_req,
  output logic              bc_valid,
  output logic [ADDR_W-1:0] bc_addr,
  output logic [TID_W-1:0]  bc_tid
);

  localparam int LINES = 1 << IDX_W;

  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  logic [IDX_W-1:0] inv_idx;
  logic [TAG_W-1:0] inv_tag;
  logic             inv_live;
  logic [LINES-1:0] hit_vec;
  logic [LINES-1:0] viol_vec;
  logic [LINES-1:0] bc_vec;
  ln_state_e        nxt_st [LINES];
  logic             halted_q;
  logic             viol_live;
  logic             do_clear;
  logic             cmd_any;

  assign req_idx  = req_addr[IDX_W-1:0];
  assign req_tag  = req_addr[ADDR_W-1:IDX_W];
  assign inv_idx  = inv_addr[IDX_W-1:0];
  assign inv_tag  = inv_addr[ADDR_W-1:IDX_W];
  assign inv_live = inv_valid && (inv_tid != own_tid);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    spec_trk_line #(.TAG_W(TAG_W), .TID_W(TID_W)) line_i (
      .clk       (clk),
      .rst       (rst),
      .own_tid   (own_tid),
      .inv_sel   (inv_live && (inv_idx == IDX_W'(i))),
      .inv_tag   (inv_tag),
      .inv_tid   (inv_tid),
      .req_sel   (req_valid && (req_idx == IDX_W'(i))),
      .req_tag   (req_tag),
      .req_write (req_write),
      .req_spec  (req_spec),
      .do_commit (commit),
      .do_clear  (do_clear),
      .hit_now   (hit_vec[i]),
      .viol      (viol_vec[i]),
      .bc_need   (bc_vec[i]),
      .nxt_state (nxt_st[i])
    );
  end

  assign viol_live = (|viol_vec) && !halted_q;
  assign do_clear  = squash_cmd || viol_live;
  assign cmd_any   = commit || do_clear;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_state <= 3'd0;
      squash_req <= 1'b0;
      bc_valid   <= 1'b0;
      bc_addr    <= '0;
      bc_tid     <= '0;
      halted_q   <= 1'b0;
    end else begin
      resp_valid <= req_valid && !cmd_any;
      resp_hit   <= hit_vec[req_idx];
      resp_state <= nxt_st[req_idx];
      squash_req <= viol_live;
      bc_valid   <= req_valid && bc_vec[req_idx];
      bc_addr    <= req_addr;
      bc_tid     <= own_tid;
      if (viol_live)    halted_q <= 1'b1;
      else if (restart) halted_q <= 1'b0;
    end
  end

endmodule

// File: rtl/spec_line_tracker_chk.sv
`timescale 1ns/1ps
module spec_line_tracker_chk #(
  parameter int TID_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [TID_W-1:0] own_tid,
  input logic             req_valid,
  input logic             inv_valid,
  input logic [TID_W-1:0] inv_tid,
  input logic             commit,
  input logic             squash_cmd,
  input logic             resp_valid,
  input logic [2:0]       resp_state,
  input logic             squash_req,
  input logic             bc_valid,
  input logic [TID_W-1:0] bc_tid
);

  AST_RESP_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !resp_valid); // R2

  AST_CMD_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
    (commit || squash_cmd) |=> (!resp_valid && !bc_valid)); // R11

  AST_BC_FROM_STORE: assert property (@(posedge clk) disable iff (rst)
    bc_valid |-> (resp_valid && (resp_state == 3'd2 || resp_state == 3'd4))); // R4

  AST_BC_TID: assert property (@(posedge clk) disable iff (rst)
    bc_valid |-> (bc_tid == $past(own_tid))); // R4

  AST_SQUASH_PULSE: assert property (@(posedge clk) disable iff (rst)
    squash_req |=> !squash_req); // R6

  AST_SQUASH_NEEDS_INV: assert property (@(posedge clk) disable iff (rst)
    !inv_valid |=> !squash_req); // R6

  AST_SELF_INV_QUIET: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && inv_tid == own_tid) |=> !squash_req); // R10

endmodule

bind spec_line_tracker spec_line_tracker_chk #(.TID_W(TID_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .own_tid    (own_tid),
  .req_valid  (req_valid),
  .inv_valid  (inv_valid),
  .inv_tid    (inv_tid),
  .commit     (commit),
  .squash_cmd (squash_cmd),
  .resp_valid (resp_valid),
  .resp_state (resp_state),
  .squash_req (squash_req),
  .bc_valid   (bc_valid),
  .bc_tid     (bc_tid)
);

// File: tb/spec_line_tracker_tb_top.sv
`timescale 1ns/1ps
module spec_line_tracker_tb_top;

  localparam int IDX_W = 3;
  localparam int TAG_W = 6;
  localparam int TID_W = 2;
  localparam int AW    = IDX_W + TAG_W;

  localparam logic [2:0] K_REQ = 3'd0;
  localparam logic [2:0] K_INV = 3'd1;
  localparam logic [2:0] K_CMT = 3'd2;
  localparam logic [2:0] K_SQC = 3'd3;
  localparam logic [2:0] K_RST = 3'd4;

  typedef struct packed {
    logic [2:0]    kind;
    logic          wr;
    logic          spec;
    logic [AW-1:0] addr;
    logic [1:0]    tid;
    logic          e_hit;
    logic [2:0]    e_st;
    logic          e_sq;
    logic          e_bc;
  } vec_t;

  localparam int NV = 35;
  // own_tid is 2; addresses are tag*8+index
  localparam vec_t VEC [NV] = '{
    '{K_REQ, 1'b0, 1'b0, 9'd41,  2'd0, 1'b0, 3'd1, 1'b0, 1'b0}, // 0  R3
    '{K_REQ, 1'b0, 1'b1, 9'd41,  2'd0, 1'b1, 3'd3, 1'b0, 1'b0}, // 1  R3
    '{K_INV, 1'b0, 1'b0, 9'd41,  2'd3, 1'b0, 3'd0, 1'b0, 1'b0}, // 2  R5
    '{K_REQ, 1'b0, 1'b0, 9'd41,  2'd0, 1'b0, 3'd1, 1'b0, 1'b0}, // 3  R5
    '{K_REQ, 1'b1, 1'b1, 9'd58,  2'd0, 1'b0, 3'd4, 1'b0, 1'b1}, // 4  R4
    '{K_REQ, 1'b1, 1'b1, 9'd58,  2'd0, 1'b1, 3'd4, 1'b0, 1'b0}, // 5  R4
    '{K_REQ, 1'b0, 1'b1, 9'd75,  2'd0, 1'b0, 3'd3, 1'b0, 1'b0}, // 6  R3
    '{K_CMT, 1'b0, 1'b0, 9'd0,   2'd0, 1'b0, 3'd0, 1'b0, 1'b0}, // 7  R7
    '{K_REQ, 1'b0, 1'b0, 9'd58,  2'd0, 1'b1, 3'd2, 1'b0, 1'b0}, // 8  R7
    '{K_REQ, 1'b0, 1'b0, 9'd75,  2'd0, 1'b1, 3'd1, 1'b0, 1'b0}, // 9  R7
    '{K_REQ, 1'b1, 1'b0, 9'd75,  2'd0, 1'b1, 3'd2, 1'b0, 1'b1}, // 10 R4
    '{K_REQ, 1'b0, 1'b1, 9'd20,  2'd0, 1'b0, 3'd3, 1'b0, 1'b0}, // 11 R3
    '{K_REQ, 1'b1, 1'b1, 9'd29,  2'd0, 1'b0, 3'd4, 1'b0, 1'b1}, // 12 R4
    '{K_SQC, 1'b0, 1'b0, 9'd0,   2'd0, 1'b0, 3'd0, 1'b0, 1'b0}, // 13 R8
    '{K_REQ, 1'b0, 1'b0, 9'd20,  2'd0, 1'b1, 3'd1, 1'b0, 1'b0}, // 14 R8
    '{K_REQ, 1'b0, 1'b0, 9'd29,  2'd0, 1'b0, 3'd1, 1'b0, 1'b0}, // 15 R8
    '{K_INV, 1'b0, 1'b0, 9'd20,  2'd0, 1'b0, 3'd0, 1'b0, 1'b0}, // 16 R5
    '{K_REQ, 1'b0, 1'b0, 9'd20,  2'd0, 1'b0, 3'd1, 1'b0, 1'b0}, // 17 R5
    '{K_REQ, 1'b0, 1'b1, 9'd38,  2'd0, 1'b0, 3'd3, 1'b0, 1'b0}, // 18 R3
    '{K_REQ, 1'b1, 1'b1, 9'd15,  2'd0, 1'b0, 3'd4, 1'b0, 1'b1}, // 19 R4
    '{K_INV, 1'b0, 1'b0, 9'd38,  2'd1, 1'b0, 3'd0, 1'b1, 1'b0}, // 20 R6
    '{K_REQ, 1'b0, 1'b0, 9'd38,  2'd0, 1'b0, 3'd1, 1'b0, 1'b0}, // 21 R6
    '{K_REQ, 1'b0, 1'b0, 9'd15,  2'd0, 1'b0, 3'd1, 1'b0, 1'b0}, // 22 R6
    '{K_REQ, 1'b0, 1'b1, 9'd38,  2'd0, 1'b1, 3'd3, 1'b0, 1'b0}, // 23 R3
    '{K_INV, 1'b0, 1'b0, 9'd38,  2'd0, 1'b0, 3'd0, 1'b0, 1'b0}, // 24 R9
    '{K_REQ, 1'b0, 1'b0, 9'd38,  2'd0, 1'b0, 3'd1, 1'b0, 1'b0}, // 25 R9
    '{K_RST, 1'b0, 1'b0, 9'd0,   2'd0, 1'b0, 3'd0, 1'b0, 1'b0}, // 26 R9
    '{K_REQ, 1'b0, 1'b1, 9'd38,  2'd0, 1'b1, 3'd3, 1'b0, 1'b0}, // 27 R3
    '{K_INV, 1'b0, 1'b0, 9'd38,  2'd1, 1'b0, 3'd0, 1'b1, 1'b0}, // 28 R9
    '{K_RST, 1'b0, 1'b0, 9'd0,   2'd0, 1'b0, 3'd0, 1'b0, 1'b0}, // 29 R9
    '{K_REQ, 1'b0, 1'b1, 9'd41,  2'd0, 1'b1, 3'd3, 1'b0, 1'b0}, // 30 R3
    '{K_INV, 1'b0, 1'b0, 9'd41,  2'd2, 1'b0, 3'd0, 1'b0, 1'b0}, // 31 R10
    '{K_REQ, 1'b0, 1'b0, 9'd41,  2'd0, 1'b1, 3'd3, 1'b0, 1'b0}, // 32 R10
    '{K_REQ, 1'b0, 1'b0, 9'd105, 2'd0, 1'b0, 3'd1, 1'b0, 1'b0}, // 33 R2
    '{K_REQ, 1'b0, 1'b0, 9'd41,  2'd0, 1'b0, 3'd1, 1'b0, 1'b0}  // 34 R2
  };

  logic              clk = 1'b0;
  logic              rst;
  logic [TID_W-1:0]  own_tid;
  logic              req_valid, req_write, req_spec;
  logic [AW-1:0]     req_addr;
  logic              inv_valid;
  logic [AW-1:0]     inv_addr;
  logic [TID_W-1:0]  inv_tid;
  logic              commit, squash_cmd, restart;
  logic              resp_valid, resp_hit;
  logic [2:0]        resp_state;
  logic              squash_req, bc_valid;
  logic [AW-1:0]     bc_addr;
  logic [TID_W-1:0]  bc_tid;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  spec_line_tracker #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TID_W(TID_W)) dut_i (
    .clk(clk), .rst(rst), .own_tid(own_tid),
    .req_valid(req_valid), .req_write(req_write), .req_spec(req_spec),
    .req_addr(req_addr), .inv_valid(inv_valid), .inv_addr(inv_addr),
    .inv_tid(inv_tid), .commit(commit), .squash_cmd(squash_cmd),
    .restart(restart), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_state(resp_state), .squash_req(squash_req), .bc_valid(bc_valid),
    .bc_addr(bc_addr), .bc_tid(bc_tid)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 0; req_write = 0; req_spec = 0; req_addr = '0;
    inv_valid = 0; inv_addr = '0; inv_tid = '0;
    commit = 0; squash_cmd = 0; restart = 0;
  endtask

  // apply for one edge, sample 1 ns after it, then release
  task automatic op(input logic rv, input logic wr, input logic sp,
                    input logic [AW-1:0] ra, input logic iv,
                    input logic [AW-1:0] ia, input logic [1:0] it,
                    input logic cm, input logic sq, input logic rs);
    @(negedge clk);
    req_valid = rv; req_write = wr; req_spec = sp; req_addr = ra;
    inv_valid = iv; inv_addr = ia; inv_tid = it;
    commit = cm; squash_cmd = sq; restart = rs;
    @(posedge clk);
    #1;
    idle_inputs();
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle_inputs();
    own_tid = 2'd2;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    check("R1 resp_valid", resp_valid, 0);
    check("R1 squash_req", squash_req, 0);
    check("R1 bc_valid", bc_valid, 0);
    for (int i = 0; i < 8; i++) begin
      op(1, 0, 0, AW'(i), 0, '0, 0, 0, 0, 0);
      check("R1 empty line hit", resp_hit, 0);
    end

    // vector table
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      t = VEC[v];
      op(t.kind == K_REQ, t.wr, t.spec, t.addr,
         t.kind == K_INV, t.addr, t.tid,
         t.kind == K_CMT, t.kind == K_SQC, t.kind == K_RST);
      check($sformatf("R2 resp_valid row %0d", v), resp_valid, int'(t.kind == K_REQ));
      if (t.kind == K_REQ) begin
        check($sformatf("R2 resp_hit row %0d", v), resp_hit, t.e_hit);
        check($sformatf("R3 resp_state row %0d", v), resp_state, t.e_st);
      end
      check($sformatf("R6 squash_req row %0d", v), squash_req, t.e_sq);
      check($sformatf("R4 bc_valid row %0d", v), bc_valid, t.e_bc);
      if (t.e_bc) begin
        check($sformatf("R4 bc_addr row %0d", v), bc_addr, t.addr);
        check($sformatf("R4 bc_tid row %0d", v), bc_tid, 2);
      end
    end

    // R8 squash command beats commit
    op(1, 1, 1, 9'd50, 0, '0, 0, 0, 0, 0);
    check("R8 setup state", resp_state, 4);
    op(0, 0, 0, '0, 0, '0, 0, 1, 1, 0);
    op(1, 0, 0, 9'd50, 0, '0, 0, 0, 0, 0);
    check("R8 squash over commit hit", resp_hit, 0);

    // R11 request dropped with a command
    op(1, 1, 1, 9'd60, 0, '0, 0, 1, 0, 0);
    check("R11 dropped resp_valid", resp_valid, 0);
    check("R11 dropped bc_valid", bc_valid, 0);
    op(1, 0, 0, 9'd60, 0, '0, 0, 0, 0, 0);
    check("R11 line untouched hit", resp_hit, 0);
    check("R11 line untouched state", resp_state, 1);

    // R12 invalidation before request on the same line (index 5 holds tag 3 shared)
    op(1, 0, 1, 9'd29, 1, 9'd29, 3, 0, 0, 0);
    check("R12 request sees invalid hit", resp_hit, 0);
    check("R12 request allocates state", resp_state, 3);
    check("R12 no squash", squash_req, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule